// File: doc/BRIEF.md
# UART interrupt priority identifier

This block gathers the interrupt causes of a 16550-style serial port and reduces them to one identification word and one interrupt line. Receive line errors, received data, the character time-out, an empty transmit holding register, modem control-line changes and two auto-baud events come in as raw conditions. Each is qualified by its bit in the interrupt-enable word. Only the most urgent qualified cause is named in the identification field, with a fixed 3-bit code. The pending flag is active low.

Most causes are levels owned by neighbouring logic and are only qualified here. The block keeps three pieces of state of its own. The first is the transmit-empty cause: it arms on the empty edge of the holding register, and a write or an identification read disarms it. The other two are the auto-baud done and auto-baud time-out flags. They are sticky and cleared by write-one strobes. The identification word is registered, so it shows the causes one clock after they are applied.

Top module: `uart_irq_ident`

## Requirements
- R1: `iir[0]` is 0 when at least one qualified cause is pending and 1 when none is. `irq` is high exactly when `iir[0]` is 0. Qualified causes are the four priority levels and the two visible auto-baud flags.
- R2: `iir[3:1]` carries the reported cause: 3'b011 line status, 3'b010 data available, 3'b110 character time-out, 3'b001 transmit holding empty, 3'b000 modem status. It also reads 3'b000 when no priority-level cause is pending. `iir[7:4]` always reads 0.
- R3: Priority, highest first: line status (enable `ier[2]`), then data available or time-out, then transmit holding empty (enable `ier[1]`), then modem status (enable `ier[3]`).
- R4: `ier[0]` alone qualifies both data available and character time-out. When both are present, data available (3'b010) is reported.
- R5: `modem_delta[0]` is the CTS-change cause and bits 3:1 are the other line changes, all qualified by `ier[3]`. When `auto_cts_en` is 1, the CTS change additionally needs `ier[7]`. The other line changes never need it.
- R6: `ab_event[i]` sets a sticky flag i. `iir[8+i]` shows the flag only while `ier[8+i]` is 1, and a shown flag counts as pending for R1.
- R7: A cycle with `ab_clear[i]` = 1 clears flag i, unless `ab_event[i]` is 1 in the same cycle, in which case the flag stays set. A cycle with `ab_clear[i]` = 0 leaves flag i unchanged, and `ab_clear` of one flag never touches the other.
- R8: The transmit-empty cause arms when `tx_hold_empty` rises from 0 to 1. A cycle with `tx_hold_wr` = 1 disarms it, and the write takes precedence over a rising edge in the same cycle.
- R9: A cycle with `id_rd` = 1, while the currently shown word reports transmit holding empty (3'b001 with `iir[0]` = 0), disarms that cause until the next empty rising edge. A read while another cause is shown leaves it armed.
- R10: After reset, `iir` is 10'h001 and `irq` is 0. A cause whose enable bit is 0 changes neither output.
- R11: `iir` and `irq` are registered. A change on any input appears at the outputs after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier | input | 10 | Interrupt-enable word |
| auto_cts_en | input | 1 | Automatic CTS flow control active |
| line_err | input | 1 | Receive line status condition |
| rx_ready | input | 1 | Receive data available condition |
| rx_timeout | input | 1 | Character time-out condition |
| tx_hold_empty | input | 1 | Transmit holding register is empty |
| tx_hold_wr | input | 1 | Write strobe to the transmit holding register |
| modem_delta | input | 4 | Modem line change flags, bit 0 is CTS |
| ab_event | input | 2 | Auto-baud done (bit 0) and time-out (bit 1) event pulses |
| ab_clear | input | 2 | Write-one clear strobes for the auto-baud flags |
| id_rd | input | 1 | Identification word read strobe |
| iir | output | 10 | Identification word |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong transmit-empty or auto-baud state bit shows on the next clock as a wrong code in `iir[3:1]`, a wrong bit 8 or 9, or a wrong `irq`. The error is only hidden while a higher-priority cause masks the code. A wrong priority or gating shows one clock after the offending input pattern. The bench compares every cycle against a behavioural model. Because of that, a wrong state that is masked at first is still caught on the first cycle the masking cause goes away.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // Enable-word bit positions; the auto-baud enables sit directly above
    // the modem-change qualifier used only with automatic CTS.
    localparam int IE_RX    = 0;
    localparam int IE_THRE  = 1;
    localparam int IE_LINE  = 2;
    localparam int IE_MODEM = 3;
    localparam int IE_CTS   = 7;
    localparam int AB_BASE  = 8;

    localparam int ID_W     = 3;
    localparam int ID_LSB   = 1;
    localparam int GAP_W    = AB_BASE - ID_LSB - ID_W;

    typedef enum logic [ID_W-1:0] {
        ID_MODEM = 3'b000,
        ID_THRE  = 3'b001,
        ID_RDA   = 3'b010,
        ID_LINE  = 3'b011,
        ID_TOUT  = 3'b110
    } irq_id_e;

endpackage

// File: rtl/uart_irq_abflag.sv
module uart_irq_abflag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag_d
);

    typedef struct packed {
        logic flag;
    } ab_state_t;

    ab_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_d = st_d.flag;

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_empty,
    input  logic hold_wr,
    input  logic id_rd,
    input  logic shown_thre,
    output logic pend_d
);

    typedef struct packed {
        logic pend;
        logic empty_prev;
    } thre_state_t;

    thre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.empty_prev = hold_empty;
        if (hold_wr) begin
            st_d.pend = 1'b0;
        end else if (hold_empty && !st_q.empty_prev) begin
            st_d.pend = 1'b1;
        end else if (id_rd && shown_thre) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_d = st_d.pend;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int AB_NUM  = 2,
    parameter int MODEM_W = 4,
    parameter int CTS_BIT = 0,
    localparam int IER_W  = AB_BASE + AB_NUM
) (
    input  logic [IER_W-1:0]   ier,
    input  logic               auto_cts_en,
    input  logic               line_err,
    input  logic               rx_ready,
    input  logic               rx_timeout,
    input  logic               thre_pend,
    input  logic [MODEM_W-1:0] modem_delta,
    input  logic [AB_NUM-1:0]  ab_flag,
    output logic [IER_W-1:0]   iir_d,
    output logic               irq_d
);

    localparam logic [MODEM_W-1:0] CTS_MASK = MODEM_W'(1) << CTS_BIT;

    logic              q_line, q_rda, q_tout, q_thre, q_modem, q_cts, q_other;
    logic [AB_NUM-1:0] ab_vis;
    irq_id_e           id;
    logic              any;

    always_comb begin
        q_line  = line_err   && ier[IE_LINE];
        q_rda   = rx_ready   && ier[IE_RX];
        q_tout  = rx_timeout && ier[IE_RX];
        q_thre  = thre_pend  && ier[IE_THRE];
        q_cts   = modem_delta[CTS_BIT] && (!auto_cts_en || ier[IE_CTS]);
        q_other = |(modem_delta & ~CTS_MASK);
        q_modem = ier[IE_MODEM] && (q_cts || q_other);
        ab_vis  = ab_flag & ier[IER_W-1:AB_BASE];

        if (q_line) begin
            id = ID_LINE;
        end else if (q_rda) begin
            id = ID_RDA;
        end else if (q_tout) begin
            id = ID_TOUT;
        end else if (q_thre) begin
            id = ID_THRE;
        end else begin
            id = ID_MODEM;
        end

        any   = q_line || q_rda || q_tout || q_thre || q_modem || (|ab_vis);
        iir_d = {ab_vis, {GAP_W{1'b0}}, id, !any};
        irq_d = any;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int AB_NUM  = 2,
    parameter int MODEM_W = 4,
    parameter int CTS_BIT = 0,
    localparam int IER_W  = AB_BASE + AB_NUM
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IER_W-1:0]   ier,
    input  logic               auto_cts_en,
    input  logic               line_err,
    input  logic               rx_ready,
    input  logic               rx_timeout,
    input  logic               tx_hold_empty,
    input  logic               tx_hold_wr,
    input  logic [MODEM_W-1:0] modem_delta,
    input  logic [AB_NUM-1:0]  ab_event,
    input  logic [AB_NUM-1:0]  ab_clear,
    input  logic               id_rd,
    output logic [IER_W-1:0]   iir,
    output logic               irq
);

    typedef struct packed {
        logic [IER_W-1:0] word;
        logic             req;
    } out_state_t;

    localparam out_state_t OUT_RST = '{word: IER_W'(1), req: 1'b0};

    out_state_t        out_d, out_q;
    logic              thre_pend_d;
    logic              shown_thre;
    logic [AB_NUM-1:0] ab_flag_d;
    logic [IER_W-1:0]  iir_next;
    logic              irq_next;
    logic              unused_rsvd;

    assign unused_rsvd = ^ier[IE_CTS-1:IE_MODEM+1];

    assign shown_thre = (out_q.word[ID_LSB +: ID_W] == ID_THRE) && !out_q.word[0];

    uart_irq_thre u_thre (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_empty (tx_hold_empty),
        .hold_wr    (tx_hold_wr),
        .id_rd      (id_rd),
        .shown_thre (shown_thre),
        .pend_d     (thre_pend_d)
    );

    for (genvar g = 0; g < AB_NUM; g++) begin : g_ab
        uart_irq_abflag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (ab_event[g]),
            .clr    (ab_clear[g]),
            .flag_d (ab_flag_d[g])
        );
    end

    uart_irq_prio #(
        .AB_NUM  (AB_NUM),
        .MODEM_W (MODEM_W),
        .CTS_BIT (CTS_BIT)
    ) u_prio (
        .ier         (ier),
        .auto_cts_en (auto_cts_en),
        .line_err    (line_err),
        .rx_ready    (rx_ready),
        .rx_timeout  (rx_timeout),
        .thre_pend   (thre_pend_d),
        .modem_delta (modem_delta),
        .ab_flag     (ab_flag_d),
        .iir_d       (iir_next),
        .irq_d       (irq_next)
    );

    always_comb begin
        out_d      = out_q;
        out_d.word = iir_next;
        out_d.req  = irq_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= OUT_RST;
        end else begin
            out_q <= out_d;
        end
    end

    assign iir = out_q.word;
    assign irq = out_q.req;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
    import uart_irq_pkg::*;
#(
    parameter int AB_NUM  = 2,
    parameter int MODEM_W = 4,
    localparam int IER_W  = AB_BASE + AB_NUM
) (
    input logic               clk,
    input logic               rst_n,
    input logic [IER_W-1:0]   ier,
    input logic               line_err,
    input logic               tx_hold_wr,
    input logic [AB_NUM-1:0]  ab_event,
    input logic [AB_NUM-1:0]  ab_clear,
    input logic [IER_W-1:0]   iir,
    input logic               irq
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    // R1: line and pending flag agree
    p_pend_irq_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        irq == !iir[0]);

    // R2: gap bits read zero
    p_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        iir[AB_BASE-1:ID_LSB+ID_W] == '0);

    // R3: qualified line status always wins
    p_line_first_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(line_err && ier[IE_LINE]) |-> (iir[3:0] == 4'b0110));

    // R4: receive codes need the receive enable
    p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$past(ier[IE_RX]) |-> (iir[3:1] != 3'b010 && iir[3:1] != 3'b110));

    // R6: done flag visible only when enabled
    p_ab_gate_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        iir[AB_BASE] |-> $past(ier[AB_BASE]));

    // R7: clear strobe without event empties the flag
    p_ab_clear_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(ab_clear[0]) && !$past(ab_event[0])) |-> !iir[AB_BASE]);

    // R8: a holding write removes the transmit-empty code
    p_thre_write_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(tx_hold_wr) |-> (iir[3:1] != 3'b001));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(
    .AB_NUM  (AB_NUM),
    .MODEM_W (MODEM_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ier        (ier),
    .line_err   (line_err),
    .tx_hold_wr (tx_hold_wr),
    .ab_event   (ab_event),
    .ab_clear   (ab_clear),
    .iir        (iir),
    .irq        (irq)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] ier = '0;
    logic       auto_cts_en = 1'b0;
    logic       line_err = 1'b0, rx_ready = 1'b0, rx_timeout = 1'b0;
    logic       tx_hold_empty = 1'b0, tx_hold_wr = 1'b0;
    logic [3:0] modem_delta = '0;
    logic [1:0] ab_event = '0, ab_clear = '0;
    logic       id_rd = 1'b0;
    logic [9:0] iir;
    logic       irq;

    always #2 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .ier(ier), .auto_cts_en(auto_cts_en),
        .line_err(line_err), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
        .tx_hold_empty(tx_hold_empty), .tx_hold_wr(tx_hold_wr),
        .modem_delta(modem_delta), .ab_event(ab_event), .ab_clear(ab_clear),
        .id_rd(id_rd), .iir(iir), .irq(irq)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R10";

    // behavioural reference state
    bit       m_thre, m_prev;
    bit [1:0] m_ab;
    bit [9:0] exp_iir = 10'h001;
    bit       model_ok = 0;

    function automatic bit [9:0] expect_word(bit thre, bit [1:0] ab);
        bit [2:0] code;
        bit       pend;
        bit       cts_ok;
        bit [1:0] vis;
        cts_ok = modem_delta[0] && (!auto_cts_en || ier[7]);
        vis    = ab & ier[9:8];
        pend   = (vis != 0);
        code   = 3'b000;
        if (ier[3] && (cts_ok || modem_delta[3:1] != 0)) pend = 1;
        if (thre && ier[1]) begin code = 3'b001; pend = 1; end
        if (rx_timeout && ier[0]) begin code = 3'b110; pend = 1; end
        if (rx_ready && ier[0]) begin code = 3'b010; pend = 1; end
        if (line_err && ier[2]) begin code = 3'b011; pend = 1; end
        return {vis, 4'b0000, code, !pend};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_thre = 0; m_prev = 0; m_ab = 0; exp_iir = 10'h001; model_ok = 0;
        end else begin
            if (tx_hold_wr) m_thre = 0;
            else if (tx_hold_empty && !m_prev) m_thre = 1;
            else if (id_rd && exp_iir[3:0] == 4'b0010) m_thre = 0;
            m_prev = tx_hold_empty;
            for (int i = 0; i < 2; i++) begin
                if (ab_event[i]) m_ab[i] = 1;
                else if (ab_clear[i]) m_ab[i] = 0;
            end
            exp_iir  = expect_word(m_thre, m_ab);
            model_ok = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_ok) begin
            checks++;
            if (iir !== exp_iir || irq !== !exp_iir[0]) begin
                failures++;
                $display("FAIL %s model compare: iir=%h irq=%b expected iir=%h irq=%b",
                         cur_req, iir, irq, exp_iir, !exp_iir[0]);
            end
        end
    end

    task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s iir=%h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_irq(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s irq=%b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            failures++;
            $display("FAIL watchdog expired: cycles=%0d expected below 50000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset", iir, 10'h001);
        chk_irq("R10 reset", irq, 1'b0);

        // R1 R2: line status alone; R11: not visible before the clock
        cur_req = "R2";
        ier = 10'h004; line_err = 1;
        #1 chk("R11 no change before edge", iir, 10'h001);
        step(); chk("R2 line code", iir, 10'h006); chk_irq("R1 irq high", irq, 1'b1);
        // R10: disabled source ignored
        cur_req = "R10";
        ier = 10'h000; step(); chk("R10 disabled line", iir, 10'h001);
        chk_irq("R1 irq low", irq, 1'b0);
        line_err = 0;

        // R4
        cur_req = "R4";
        ier = 10'h001; rx_timeout = 1; step(); chk("R2 timeout code", iir, 10'h00C);
        rx_ready = 1; step(); chk("R4 data over timeout", iir, 10'h004);
        ier = 10'h000; step(); chk("R4 receive gate", iir, 10'h001);
        rx_ready = 0; rx_timeout = 0;

        // R8
        cur_req = "R8";
        ier = 10'h002; tx_hold_empty = 1; step(); chk("R8 empty edge arms", iir, 10'h002);
        tx_hold_wr = 1; step(); tx_hold_wr = 0; chk("R8 write disarms", iir, 10'h001);
        tx_hold_empty = 0; step(); tx_hold_empty = 1; step();
        chk("R8 rearm", iir, 10'h002);

        // R9
        cur_req = "R9";
        id_rd = 1; step(); id_rd = 0; chk("R9 read clears", iir, 10'h001);
        step(); chk("R9 stays clear", iir, 10'h001);
        tx_hold_empty = 0; step(); tx_hold_empty = 1;
        ier = 10'h006; line_err = 1; step(); chk("R3 line over thre", iir, 10'h006);
        id_rd = 1; step(); id_rd = 0; chk("R9 read other", iir, 10'h006);
        line_err = 0; step(); chk("R9 thre kept", iir, 10'h002);
        tx_hold_wr = 1; step(); tx_hold_wr = 0; chk("R8 write", iir, 10'h001);

        // R5
        cur_req = "R5";
        ier = 10'h008; modem_delta = 4'b0001; step(); chk("R5 cts plain", iir, 10'h000);
        auto_cts_en = 1; step(); chk("R5 cts auto masked", iir, 10'h001);
        ier = 10'h088; step(); chk("R5 cts auto enabled", iir, 10'h000);
        ier = 10'h008; modem_delta = 4'b0010; step(); chk("R5 other delta", iir, 10'h000);
        modem_delta = 0; auto_cts_en = 0;

        // R6 R7
        cur_req = "R6";
        ier = 10'h000; ab_event = 2'b01; step(); ab_event = 0;
        chk("R6 hidden flag", iir, 10'h001);
        ier = 10'h100; step(); chk("R6 shown flag", iir, 10'h100);
        chk_irq("R6 irq", irq, 1'b1);
        cur_req = "R7";
        step(); chk("R7 no strobe", iir, 10'h100);
        ab_clear = 2'b10; step(); chk("R7 other clear", iir, 10'h100);
        ab_clear = 2'b01; ab_event = 2'b01; step(); chk("R7 event wins", iir, 10'h100);
        ab_event = 0; step(); ab_clear = 0; chk("R7 clear", iir, 10'h001);
        ier = 10'h200; ab_event = 2'b10; step(); ab_event = 0;
        chk("R6 timeout flag", iir, 10'h200);
        ab_clear = 2'b01; step(); chk("R7 wrong clear", iir, 10'h200);
        ab_clear = 2'b10; step(); ab_clear = 0; chk("R7 timeout clear", iir, 10'h001);

        // R3 combined
        cur_req = "R3";
        ier = 10'h30C; ab_event = 2'b11; line_err = 1; modem_delta = 4'b0001;
        step(); ab_event = 0; chk("R3 combined", iir, 10'h306);
        ab_clear = 2'b11; line_err = 0; step(); ab_clear = 0;
        chk("R3 modem last", iir, 10'h000);
        modem_delta = 0; ier = 0; step(); chk("R1 idle", iir, 10'h001);

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            ier           = 10'($urandom);
            auto_cts_en   = 1'($urandom);
            line_err      = ($urandom % 5) == 0;
            rx_ready      = ($urandom % 3) == 0;
            rx_timeout    = ($urandom % 3) == 0;
            tx_hold_empty = ($urandom % 2) == 0;
            tx_hold_wr    = ($urandom % 6) == 0;
            modem_delta   = 4'($urandom) & 4'($urandom);
            ab_event      = 2'($urandom) & 2'($urandom) & 2'($urandom);
            ab_clear      = 2'($urandom) & 2'($urandom);
            id_rd         = ($urandom % 3) == 0;
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule